// File: doc/BRIEF.md
# Highway and Farm-Road Junction Lamp Controller

This block sequences the lamps at a crossing where a busy highway meets a farm road that carries little traffic. The highway keeps its green by default. A vehicle detector on the farm road, `carWaiting`, asks for the farm road to get green. Once it has, the farm road keeps green only while vehicles remain, and never longer than the long interval. The highway also has a guaranteed minimum green time, so a steady stream of farm-road requests cannot starve it.

Every phase is timed by one interval counter inside the block. The controller sends the counter a restart strobe on every phase change. The counter then raises a short-interval flag and a long-interval flag. Yellow phases wait on the short flag and green phases wait on the long flag. Both interval lengths are parameters, given in clock cycles. `SHORT_CYCLES` must be at least 1 and smaller than `LONG_CYCLES`.

Top module: `junction_ctrl`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), and in the first cycle after it is released, the highway shows green and the farm road shows red, and the phase age is zero. The phase age is the number of rising edges since the current phase was entered.
- R2: Each lamp bus is one-hot, with bit 0 = green, bit 1 = yellow and bit 2 = red. In every cycle exactly one lamp per road is lit, and whichever road is not showing red forces the other road to red.
- R3: While `carWaiting` is low, highway green is held indefinitely.
- R4: Highway green changes to highway yellow at the rising edge that ends the first cycle in which `carWaiting` is high and the phase age is at least `LONG_CYCLES`. Highway green therefore always lasts at least `LONG_CYCLES`+1 cycles.
- R5: Highway yellow lasts exactly `SHORT_CYCLES`+1 cycles and then changes to farm green.
- R6: Farm green changes to farm yellow at the rising edge that ends the first cycle in which `carWaiting` is low or the phase age is at least `LONG_CYCLES`.
- R7: Farm yellow lasts exactly `SHORT_CYCLES`+1 cycles and then changes to highway green.
- R8: The interval counter restarts on every phase change. As a result, each phase is timed from its own entry, whatever time the previous phase took.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carWaiting | input | 1 | Farm-road vehicle detector, synchronous to `clk` |
| hwyLamp | output | 3 | Highway lamps, one-hot {red, yellow, green} |
| farmLamp | output | 3 | Farm-road lamps, one-hot {red, yellow, green} |

## Verification
The assertions assume the following about the inputs:
- `carWaiting` is already synchronous to `clk` and settled before each rising edge.
- The parameters keep the short interval strictly below the long one, so the long flag can never be set while the short flag is clear.

The bench keeps within these assumptions:
- It changes `carWaiting` only on falling edges.
- It uses a short interval of 3 cycles and a long interval of 8 cycles.

Within those limits the bench sweeps the cycle at which a request arrives across the whole highway minimum window. It also sweeps the cycle at which the farm road empties across the whole farm green window. Finally, it applies a long pseudo-random request pattern and a reset in the middle of a phase.

// File: rtl/junction_pkg.sv
package junction_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  // Lamp bit positions inside each one-hot road bus
  localparam int LAMP_GREEN  = 0;
  localparam int LAMP_YELLOW = 1;
  localparam int LAMP_RED    = 2;
  localparam int LAMP_W      = 3;

  // Strobes from control to the interval datapath
  typedef struct packed {
    logic restart;
  } ctrl_strobe_t;

  // Status from the interval datapath back to control
  typedef struct packed {
    logic shortDone;
    logic longDone;
  } tmr_status_t;

endpackage

// File: rtl/junction_timer.sv
module junction_timer
  import junction_pkg::*;
#(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output tmr_status_t  status
);

  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES);

  logic [CW-1:0] ageCnt;

  // Counts phase age and saturates at the long limit, so both flags stay set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt <= '0;
    end else if (strobe.restart) begin
      ageCnt <= '0;
    end else if (ageCnt != LONG_LIM) begin
      ageCnt <= ageCnt + 1'b1;
    end
  end

  always_comb begin
    status.shortDone = (ageCnt >= SHORT_LIM);
    status.longDone  = (ageCnt >= LONG_LIM);
  end

endmodule

// File: rtl/junction_fsm.sv
module junction_fsm
  import junction_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              carWaiting,
  input  tmr_status_t       status,
  output ctrl_strobe_t      strobe,
  output logic [LAMP_W-1:0] hwyLamp,
  output logic [LAMP_W-1:0] farmLamp
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_HWY_GO;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_HWY_GO:    if (carWaiting && status.longDone)  phaseNext = PH_HWY_WARN;
      PH_HWY_WARN:  if (status.shortDone)               phaseNext = PH_FARM_GO;
      PH_FARM_GO:   if (!carWaiting || status.longDone) phaseNext = PH_FARM_WARN;
      PH_FARM_WARN: if (status.shortDone)               phaseNext = PH_HWY_GO;
      default:      phaseNext = PH_HWY_GO;
    endcase
  end

  // Restart the interval counter on every phase exit
  always_comb strobe.restart = (phaseNext != phase);

  always_comb begin
    hwyLamp  = '0;
    farmLamp = '0;
    unique case (phase)
      PH_HWY_GO:    begin hwyLamp[LAMP_GREEN]  = 1'b1; farmLamp[LAMP_RED]    = 1'b1; end
      PH_HWY_WARN:  begin hwyLamp[LAMP_YELLOW] = 1'b1; farmLamp[LAMP_RED]    = 1'b1; end
      PH_FARM_GO:   begin hwyLamp[LAMP_RED]    = 1'b1; farmLamp[LAMP_GREEN]  = 1'b1; end
      PH_FARM_WARN: begin hwyLamp[LAMP_RED]    = 1'b1; farmLamp[LAMP_YELLOW] = 1'b1; end
      default:      begin hwyLamp[LAMP_GREEN]  = 1'b1; farmLamp[LAMP_RED]    = 1'b1; end
    endcase
  end

endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import junction_pkg::*;
#(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carWaiting,
  output logic [2:0] hwyLamp,
  output logic [2:0] farmLamp
);

  ctrl_strobe_t ctlStrobe;
  tmr_status_t  tmrStatus;

  junction_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .carWaiting (carWaiting),
    .status     (tmrStatus),
    .strobe     (ctlStrobe),
    .hwyLamp    (hwyLamp),
    .farmLamp   (farmLamp)
  );

  junction_timer #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctlStrobe),
    .status (tmrStatus)
  );

endmodule

// File: rtl/junction_ctrl_chk.sv
module junction_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       carWaiting,
  input logic [2:0] hwyLamp,
  input logic [2:0] farmLamp,
  input logic       restart,
  input logic       tsFlag,
  input logic       tlFlag
);

  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(hwyLamp) == 1) && ($countones(farmLamp) == 1)); // R2

  AST_CROSS_RED: assert property (@(posedge clk) disable iff (!rstN)
    !hwyLamp[2] |-> farmLamp[2]); // R2

  AST_HWY_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (hwyLamp[0] && !carWaiting) |=> hwyLamp[0]); // R3

  AST_HWY_MIN_GREEN: assert property (@(posedge clk) disable iff (!rstN)
    (hwyLamp[0] && !tlFlag) |=> hwyLamp[0]); // R4

  AST_HWY_YELLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hwyLamp[1] && !tsFlag) |=> hwyLamp[1]); // R5

  AST_FARM_EMPTY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (farmLamp[0] && !carWaiting) |=> farmLamp[1]); // R6

  AST_FARM_YELLOW_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (farmLamp[1] && tsFlag) |=> hwyLamp[0]); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!tsFlag && !tlFlag)); // R8

  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    tlFlag |-> tsFlag); // R8

  AST_LAMPS_MOVE_ON_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !restart |=> $stable(hwyLamp) && $stable(farmLamp)); // R8

endmodule

bind junction_ctrl junction_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .carWaiting (carWaiting),
  .hwyLamp    (hwyLamp),
  .farmLamp   (farmLamp),
  .restart    (ctlStrobe.restart),
  .tsFlag     (tmrStatus.shortDone),
  .tlFlag     (tmrStatus.longDone)
);

// File: tb/tb_junction_ctrl.sv
`timescale 1ns/1ps
module tb_junction_ctrl;

  localparam int S = 3;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carWaiting = 1'b0;
  logic [2:0] hwyLamp, farmLamp;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;   // expected phase: 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int age    = 0;   // expected cycles since phase entry
  logic lastC = 1'b0;

  always #4 clk = ~clk;

  junction_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .carWaiting (carWaiting),
    .hwyLamp    (hwyLamp),
    .farmLamp   (farmLamp)
  );

  // Lamp encodings from R2: bit0 green, bit1 yellow, bit2 red
  function automatic logic [5:0] expLamps(int p);
    case (p)
      0:       return {3'b100, 3'b001};
      1:       return {3'b100, 3'b010};
      2:       return {3'b001, 3'b100};
      default: return {3'b010, 3'b100};
    endcase
  endfunction

  task automatic checkLamps(string tag);
    logic [5:0] e;
    e = expLamps(ph);
    checks++;
    if ({farmLamp, hwyLamp} !== e) begin
      fails++;
      $display("FAIL %s R2 ph=%0d age=%0d: hwy=%b farm=%b expected hwy=%b farm=%b",
               tag, ph, age, hwyLamp, farmLamp, e[2:0], e[5:3]);
    end
  endtask

  function automatic string phaseTag();
    case (ph)
      0:       return lastC ? "R4" : "R3";
      1:       return "R5 R8";
      2:       return "R6";
      default: return "R7 R8";
    endcase
  endfunction

  // Model advance for the coming rising edge, from R3..R8
  task automatic advance(logic c);
    bit go;
    case (ph)
      0:       go = c && (age >= L);
      1:       go = (age >= S);
      2:       go = !c || (age >= L);
      default: go = (age >= S);
    endcase
    if (go) begin ph = (ph + 1) % 4; age = 0; end
    else    age++;
  endtask

  task automatic step(logic c);
    @(negedge clk);
    checkLamps(phaseTag());
    lastC = c;
    carWaiting = c;
    advance(c);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    carWaiting = 1'b0;
    lastC = 1'b0;
    ph = 0;
    age = 0;
    @(negedge clk);
    checkLamps("R1");
    @(negedge clk);
    rstN = 1'b1;
    checkLamps("R1");
    advance(1'b0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    doReset();

    // R3: no request, highway green holds
    repeat (40) step(1'b0);

    // R4 with R5..R7: request arriving at every offset across the minimum window
    for (int d = 0; d <= L + 3; d++) begin
      doReset();
      repeat (d) step(1'b0);
      repeat (2 * (L + S) + 8) step(1'b1);
    end

    // R6: farm road empties at each point in its green window
    for (int k = 0; k <= L + 2; k++) begin
      doReset();
      while (ph != 2) step(1'b1);
      repeat (k) step(1'b1);
      repeat (L + 2 * S + 6) step(1'b0);
    end

    // Pseudo-random request pattern with a mid-phase reset (R1, R8)
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3]);
      if (n == 1500) doReset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule